// File: doc/BRIEF.md
# Network Transfer Block Datagram Extractor

This block receives one aggregated network transfer block at a time as a byte stream with a last-byte marker and stores it in a local byte buffer. When the block is complete, it validates the fixed 12-byte header. It then follows the header's index to a pointer table and walks that table entry by entry. Each entry locates one datagram inside the block. Every valid datagram is sent out as its own frame on a byte stream that carries start and end markers.

Tables may be chained through a next-table index, and every table in the chain is walked. A broken entry is skipped on its own and reported, while the entries that follow it are still delivered. A whole block is dropped when its signature is wrong or when its length field disagrees with the byte count. A one-cycle flag reports a break in the running sequence number. All multi-byte fields are little-endian and all indices are byte offsets from the first byte of the block.

Top module: `ncm_ntb_parser`

## Requirements
- R1: A block whose bytes 0..3 are not the ASCII characters N, C, M, H, in that order, is discarded with no datagram output, and err_sig pulses high for exactly one cycle.
- R2: The header holds the sequence number at bytes 4..5, the block length at bytes 6..7 and the first table index at bytes 8..9; bytes 10..11 are ignored. If fewer than 12 bytes arrive, more than DEPTH bytes arrive, or the length field differs from the received byte count, the block is discarded and err_len pulses for one cycle. The signature test takes priority when at least 12 bytes arrive.
- R3: A table at index t holds the next-table index at t..t+1, followed by 4-byte entries (offset at +0..1, length at +2..3). Each valid entry produces the block bytes offset..offset+length-1, one per cycle, with out_sof on the first byte and out_eof on the last.
- R4: Tables are walked in chain order. A table index of zero, whether from the header or from a next field, ends the walk without error. At most MAX_TABLES tables are walked per block. A table whose next field would extend past the block end ends the walk, and err_entry pulses.
- R5: An all-zero entry ends the current table. So does an entry that would extend past the block end. In both cases the walk moves on to the next table.
- R6: An entry with zero length, or with offset+length greater than the block length, is skipped and err_entry pulses for one cycle. The later entries are still delivered.
- R7: Datagrams leave in table order, whatever their offsets.
- R8: For each accepted block after the first, err_seq pulses for one cycle when its sequence number is not the previous accepted block's number plus one, modulo 2^16.
- R9: in_ready is low from the cycle after the last byte is accepted until the walk ends. Bytes of one datagram are contiguous, and out_valid is low for at least one cycle after each out_eof.
- R10: After reset, in_ready is high and all outputs and flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a block |
| in_ready | output | 1 | Block can accept a byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output datagram byte |
| out_sof | output | 1 | First byte of a datagram |
| out_eof | output | 1 | Last byte of a datagram |
| err_sig | output | 1 | Bad signature pulse |
| err_len | output | 1 | Length mismatch pulse |
| err_entry | output | 1 | Skipped entry or bad table pulse |
| err_seq | output | 1 | Sequence gap pulse |

## Verification
A wrong table or entry pointer in the walker shows up as a wrong out_data byte, or a misplaced start or end marker, on the very first byte it affects. The reference queue catches that byte in the same cycle it appears. A stale chain index or a wrong entry check shows as missing or extra datagrams, and as an err_entry count that differs from expectation by the end of that block. A corrupted previous-sequence register shows as a wrong err_seq on the next accepted block.

// File: rtl/ncm_pkg.sv
package ncm_pkg;
  localparam int HDR_BYTES  = 12;
  localparam int HDR_CAPT   = 10;
  localparam int RD_PORTS   = 4;

  typedef enum logic [1:0] {W_IDLE, W_TBL, W_ENT, W_OUT} walk_state_e;

  function automatic logic [15:0] le16(input logic [7:0] lo, input logic [7:0] hi);
    return {hi, lo};
  endfunction

  function automatic logic span_fits(input logic [15:0] off, input logic [15:0] len,
                                     input logic [16:0] lim);
    return ({2'b00, off} + {2'b00, len}) <= {1'b0, lim};
  endfunction
endpackage

// File: rtl/ncm_blk_store.sv
module ncm_blk_store import ncm_pkg::*; #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [7:0]                     in_data,
  input  logic                           in_last,
  input  logic                           walk_idle,
  output logic                           in_ready,
  output logic                           blk_done,
  output logic [16:0]                    blk_bytes,
  output logic [HDR_CAPT-1:0][7:0]       hdr,
  input  logic [RD_PORTS-1:0][AW-1:0]    rd_addr,
  output logic [RD_PORTS-1:0][7:0]       rd_data
);
  logic [7:0]  mem [DEPTH];
  logic [16:0] cnt;
  logic        take;

  assign in_ready = walk_idle && !blk_done;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      blk_done  <= 1'b0;
      blk_bytes <= '0;
      hdr       <= '0;
    end else begin
      blk_done <= take && in_last;
      if (take) begin
        if (cnt < 17'(HDR_CAPT)) hdr[cnt[3:0]] <= in_data;
        if (in_last) begin
          blk_bytes <= (cnt == '1) ? cnt : cnt + 17'd1;
          cnt       <= '0;
        end else if (cnt != '1) begin
          cnt <= cnt + 17'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take && cnt < 17'(DEPTH)) mem[cnt[AW-1:0]] <= in_data;
  end

  for (genvar k = 0; k < RD_PORTS; k++) begin : g_rd
    assign rd_data[k] = mem[rd_addr[k]];
  end

  p_ready_drops_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_last) |=> !in_ready);
endmodule

// File: rtl/ncm_hdr_check.sv
module ncm_hdr_check import ncm_pkg::*; #(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     chk,
  input  logic [HDR_CAPT-1:0][7:0] hdr,
  input  logic [16:0]              blk_bytes,
  output logic                     accept,
  output logic [15:0]              tbl_idx,
  output logic [15:0]              blk_len,
  output logic                     err_sig,
  output logic                     err_len,
  output logic                     err_seq
);
  logic        too_short, sig_ok, len_ok;
  logic [15:0] seq, prev_seq;
  logic        have_prev;

  assign seq       = le16(hdr[4], hdr[5]);
  assign blk_len   = le16(hdr[6], hdr[7]);
  assign tbl_idx   = le16(hdr[8], hdr[9]);
  assign too_short = blk_bytes < 17'(HDR_BYTES);
  assign sig_ok    = hdr[0] == 8'h4E && hdr[1] == 8'h43 && hdr[2] == 8'h4D && hdr[3] == 8'h48;
  assign len_ok    = {1'b0, blk_len} == blk_bytes && blk_bytes <= 17'(DEPTH);
  assign accept    = chk && !too_short && sig_ok && len_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_sig   <= 1'b0;
      err_len   <= 1'b0;
      err_seq   <= 1'b0;
      prev_seq  <= '0;
      have_prev <= 1'b0;
    end else begin
      err_sig <= chk && !too_short && !sig_ok;
      err_len <= chk && (too_short || (sig_ok && !len_ok));
      err_seq <= accept && have_prev && (seq != prev_seq + 16'd1);
      if (accept) begin
        prev_seq  <= seq;
        have_prev <= 1'b1;
      end
    end
  end

  p_block_errs_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_sig && err_len));
  p_seq_flag_follows_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_seq |-> $past(accept));
  p_sig_flag_single_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err_sig |=> !err_sig);
endmodule

// File: rtl/ncm_walker.sv
module ncm_walker import ncm_pkg::*; #(
  parameter int DEPTH      = 256,
  parameter int MAX_TABLES = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int TW = $clog2(MAX_TABLES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [15:0]                 tbl_idx,
  input  logic [15:0]                 blk_len,
  output logic [RD_PORTS-1:0][AW-1:0] rd_addr,
  input  logic [RD_PORTS-1:0][7:0]    rd_data,
  output logic                        out_valid,
  output logic [7:0]                  out_data,
  output logic                        out_sof,
  output logic                        out_eof,
  output logic                        err_entry,
  output logic                        idle
);
  walk_state_e st;
  logic [16:0] p, e, cur, len_q, base;
  logic [15:0] rem, nxt, ent_off, ent_len;
  logic [TW-1:0] tcnt;
  logic first, ent_room, tbl_room, ent_end, ent_ok, chain_end;

  always_comb begin
    case (st)
      W_TBL:   base = p;
      W_ENT:   base = e;
      default: base = cur;
    endcase
  end

  for (genvar k = 0; k < RD_PORTS; k++) begin : g_addr
    assign rd_addr[k] = base[AW-1:0] + AW'(k);
  end

  assign ent_off   = le16(rd_data[0], rd_data[1]);
  assign ent_len   = le16(rd_data[2], rd_data[3]);
  assign ent_room  = (e + 17'd4) <= len_q;
  assign tbl_room  = (p + 17'd2) <= len_q;
  assign ent_end   = ent_off == '0 && ent_len == '0;
  assign ent_ok    = ent_len != '0 && span_fits(ent_off, ent_len, len_q);
  assign chain_end = p == '0 || tcnt == TW'(MAX_TABLES);
  assign idle      = st == W_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= W_IDLE;
      p <= '0; e <= '0; cur <= '0; len_q <= '0;
      rem <= '0; nxt <= '0; tcnt <= '0; first <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; out_sof <= 1'b0; out_eof <= 1'b0;
      err_entry <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      err_entry <= 1'b0;
      case (st)
        W_IDLE: if (start) begin
          p     <= {1'b0, tbl_idx};
          len_q <= {1'b0, blk_len};
          tcnt  <= '0;
          st    <= W_TBL;
        end
        W_TBL: begin
          if (chain_end) begin
            st <= W_IDLE;
          end else if (!tbl_room) begin
            err_entry <= 1'b1;
            st        <= W_IDLE;
          end else begin
            nxt  <= le16(rd_data[0], rd_data[1]);
            e    <= p + 17'd2;
            tcnt <= tcnt + TW'(1);
            st   <= W_ENT;
          end
        end
        W_ENT: begin
          if (!ent_room || ent_end) begin
            p  <= {1'b0, nxt};
            st <= W_TBL;
          end else if (!ent_ok) begin
            err_entry <= 1'b1;
            e         <= e + 17'd4;
          end else begin
            cur   <= {1'b0, ent_off};
            rem   <= ent_len;
            first <= 1'b1;
            st    <= W_OUT;
          end
        end
        default: begin
          out_valid <= 1'b1;
          out_data  <= rd_data[0];
          out_sof   <= first;
          out_eof   <= rem == 16'd1;
          first     <= 1'b0;
          cur       <= cur + 17'd1;
          rem       <= rem - 16'd1;
          if (rem == 16'd1) begin
            e  <= e + 17'd4;
            st <= W_ENT;
          end
        end
      endcase
    end
  end

  p_markers_need_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eof) |-> out_valid);
  p_gap_after_eof_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |=> !out_valid);
  p_contiguous_bytes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sof) |-> $past(out_valid));
  p_skip_emits_nothing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_entry |-> !out_valid);
  p_table_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= TW'(MAX_TABLES));
endmodule

// File: rtl/ncm_ntb_parser.sv
module ncm_ntb_parser import ncm_pkg::*; #(
  parameter int DEPTH      = 256,
  parameter int MAX_TABLES = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof,
  output logic       err_sig,
  output logic       err_len,
  output logic       err_entry,
  output logic       err_seq
);
  logic                        walk_idle, blk_done, accept;
  logic [16:0]                 blk_bytes;
  logic [HDR_CAPT-1:0][7:0]    hdr;
  logic [RD_PORTS-1:0][AW-1:0] rd_addr;
  logic [RD_PORTS-1:0][7:0]    rd_data;
  logic [15:0]                 tbl_idx, blk_len;

  ncm_blk_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .walk_idle(walk_idle), .in_ready(in_ready), .blk_done(blk_done), .blk_bytes(blk_bytes),
    .hdr(hdr), .rd_addr(rd_addr), .rd_data(rd_data));

  ncm_hdr_check #(.DEPTH(DEPTH)) u_hdr (
    .clk(clk), .rst_n(rst_n), .chk(blk_done), .hdr(hdr), .blk_bytes(blk_bytes),
    .accept(accept), .tbl_idx(tbl_idx), .blk_len(blk_len),
    .err_sig(err_sig), .err_len(err_len), .err_seq(err_seq));

  ncm_walker #(.DEPTH(DEPTH), .MAX_TABLES(MAX_TABLES)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(accept), .tbl_idx(tbl_idx), .blk_len(blk_len),
    .rd_addr(rd_addr), .rd_data(rd_data), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .err_entry(err_entry), .idle(walk_idle));

  p_no_intake_mid_datagram_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eof) |-> !in_ready);
  p_rejected_block_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sig || err_len) |=> !out_valid);
endmodule

// File: tb/test_ncm_ntb_parser.sv
module test_ncm_ntb_parser;
  localparam int DEPTH = 256;
  localparam int MAXT  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_sof, out_eof, err_sig, err_len, err_entry, err_seq;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  ncm_ntb_parser #(.DEPTH(DEPTH), .MAX_TABLES(MAXT)) i_ncm_ntb_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .err_sig(err_sig), .err_len(err_len), .err_entry(err_entry),
    .err_seq(err_seq));

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  byte unsigned img [0:319];
  int exp_q[$];
  int n_sig, n_len, n_ent, n_seq;
  int prev_seq = 0;
  bit have_prev = 1'b0;
  string cur_req = "R3";

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid) begin
        int got;
        got = {22'd0, out_sof, out_eof, out_data};
        if (exp_q.size() == 0) check(1'b0, cur_req, got, -1);
        else begin
          int w;
          w = exp_q.pop_front();
          check(got == w, cur_req, got, w);
        end
      end
      n_sig += int'(err_sig);
      n_len += int'(err_len);
      n_ent += int'(err_entry);
      n_seq += int'(err_seq);
    end
  end

  function automatic int rd16(input int a);
    return int'(img[a]) | (int'(img[a+1]) << 8);
  endfunction

  task automatic put16(input int a, input int v);
    img[a]   = 8'(v);
    img[a+1] = 8'(v >> 8);
  endtask

  task automatic new_img(input int seq, input int blen, input int tbl, input int seed);
    for (int i = 0; i < 320; i++) img[i] = 8'(i * 7 + seed);
    img[0] = 8'h4E; img[1] = 8'h43; img[2] = 8'h4D; img[3] = 8'h48;
    put16(4, seq); put16(6, blen); put16(8, tbl);
  endtask

  // behavioural model: returns expected flag counts and fills exp_q
  task automatic model(input int n, output int es, output int el, output int eq, output int ee);
    int p, tables, nxt, e, off, ln, blen;
    es = 0; el = 0; eq = 0; ee = 0;
    if (n < 12) begin el = 1; return; end
    if (!(img[0] == 8'h4E && img[1] == 8'h43 && img[2] == 8'h4D && img[3] == 8'h48)) begin
      es = 1; return;
    end
    if (rd16(6) != n || n > DEPTH) begin el = 1; return; end
    if (have_prev && rd16(4) != ((prev_seq + 1) % 65536)) eq = 1;
    prev_seq = rd16(4); have_prev = 1'b1;
    blen = n; p = rd16(8); tables = 0;
    while (p != 0 && tables < MAXT) begin
      if (p + 2 > blen) begin ee++; break; end
      nxt = rd16(p); e = p + 2; tables++;
      while (e + 4 <= blen) begin
        off = rd16(e); ln = rd16(e + 2);
        if (off == 0 && ln == 0) break;
        if (ln == 0 || off + ln > blen) ee++;
        else for (int i = 0; i < ln; i++)
          exp_q.push_back(((i == 0) ? 512 : 0) | ((i == ln - 1) ? 256 : 0) | int'(img[off + i]));
        e += 4;
      end
      p = nxt;
    end
  endtask

  task automatic run_block(input int n, input string req);
    int es, el, eq, ee;
    cur_req = req;
    exp_q.delete();
    model(n, es, el, eq, ee);
    n_sig = 0; n_len = 0; n_ent = 0; n_seq = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = img[i]; in_last = (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    check(in_ready == 1'b0, {req, " R9 ready low after last"}, int'(in_ready), 0);
    while (!in_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, {req, " missing bytes"}, exp_q.size(), 0);
    check(n_sig == es, {req, " R1 err_sig"}, n_sig, es);
    check(n_len == el, {req, " R2 err_len"}, n_len, el);
    check(n_ent == ee, {req, " R6 err_entry"}, n_ent, ee);
    check(n_seq == eq, {req, " R8 err_seq"}, n_seq, eq);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    check(in_ready && !out_valid && !out_sof && !out_eof, "R10 outputs", int'(in_ready), 1);
    check(!err_sig && !err_len && !err_entry && !err_seq, "R10 flags",
          int'({err_sig, err_len, err_entry, err_seq}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3/R5: two datagrams, single table ending with a zero entry
    new_img(1, 64, 40, 3);
    put16(40, 0); put16(42, 12); put16(44, 5); put16(46, 20); put16(48, 3);
    put16(50, 0); put16(52, 0);
    run_block(64, "R3");

    // R4/R7: chained tables, table order differs from offset order
    new_img(2, 80, 50, 11);
    put16(50, 66); put16(52, 30); put16(54, 2); put16(56, 12); put16(58, 4);
    put16(60, 0); put16(62, 0);
    put16(66, 0); put16(68, 16); put16(70, 6); put16(72, 0); put16(74, 0);
    run_block(80, "R7");

    // R1: bad signature
    new_img(3, 64, 40, 5);
    img[0] = 8'h58;
    put16(40, 0); put16(42, 12); put16(44, 5); put16(46, 0); put16(48, 0);
    run_block(64, "R1");

    // R2: length field disagrees with byte count
    new_img(3, 64, 40, 5);
    put16(40, 0); put16(42, 12); put16(44, 5); put16(46, 0); put16(48, 0);
    run_block(60, "R2");

    // R6: out-of-range and zero-length entries skipped, later ones delivered
    new_img(3, 64, 40, 9);
    put16(40, 0); put16(42, 12); put16(44, 4); put16(46, 60); put16(48, 10);
    put16(50, 20); put16(52, 0); put16(54, 16); put16(56, 2); put16(58, 0); put16(60, 0);
    run_block(64, "R6");

    // R5: table runs to block end with no terminating entry
    new_img(4, 48, 38, 13);
    put16(38, 0); put16(40, 12); put16(42, 3); put16(44, 15); put16(46, 1);
    run_block(48, "R5");

    // R8: sequence gap, then another gap, then wrap with no gap
    new_img(9, 32, 20, 17);
    put16(20, 0); put16(22, 12); put16(24, 2); put16(26, 0); put16(28, 0);
    run_block(32, "R8");
    new_img(16'hFFFF, 32, 20, 19);
    put16(20, 0); put16(22, 12); put16(24, 2); put16(26, 0); put16(28, 0);
    run_block(32, "R8");
    new_img(0, 32, 20, 23);
    put16(20, 0); put16(22, 12); put16(24, 2); put16(26, 0); put16(28, 0);
    run_block(32, "R8");

    // R4: header table index zero gives nothing; table past end flags an entry error
    new_img(1, 32, 0, 29);
    run_block(32, "R4");
    new_img(2, 63, 62, 31);
    run_block(63, "R4");

    // R4: self-linked table stops after MAX_TABLES passes
    new_img(3, 40, 20, 37);
    put16(20, 20); put16(22, 12); put16(24, 2); put16(26, 0); put16(28, 0);
    run_block(40, "R4");

    // R2: short block and oversized block
    new_img(4, 8, 0, 41);
    run_block(8, "R2");
    new_img(4, 300, 20, 43);
    run_block(300, "R2");

    // R3: one-byte datagram followed by a long one
    new_img(4, 120, 100, 47);
    put16(100, 0); put16(102, 99); put16(104, 1); put16(106, 12); put16(108, 80);
    put16(110, 0); put16(112, 0);
    run_block(120, "R3");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule